// File: doc/BRIEF.md
# Reset-Cause and Wake-Up Controller

This block sits beside the execution core of a small microcontroller. It watches five event sources: a power-rise pulse, an active-low external clear pin, a watchdog expiry, a pending interrupt and the core's sleep indicator. In every clock cycle it sorts what it sees into exactly one of six conditions. For each condition it produces the core's response: a next program counter with a load strobe, a rewritten status byte carrying the time-out and power-down flags, and, for the conditions that are real resets, a held chip reset.

There are three kinds of reset: power-on, external clear and watchdog expiry while running. These force the program counter to zero and raise chip reset. After power-on, chip reset stays high until a start-up counter has run down. After an external clear, it stays high for as long as the filtered pin stays low. A watchdog expiry or an interrupt that arrives while the core sleeps does not reset anything. Execution resumes at the next instruction, or at the interrupt vector when global interrupts are enabled. The external clear first passes a digital glitch filter that counts consecutive low samples.

Top module: `rstwake_ctrl`

## Requirements
- R1: When several events are sampled in the same cycle, exactly one condition is applied, in this priority: power-rise, then accepted clear, then watchdog, then interrupt.
- R2: Power-on: the next PC is 0 and chip reset rises. In the status byte, bits 7:5 are 0, bit 4 (time-out) is 1 and bit 3 (power-down) is 1. Bits 2:0 pass from status_i.
- R3: After the last cycle in which por_pulse_i was sampled high, chip reset stays high for exactly STARTUP_CYC+1 further cycles and then falls.
- R4: A clear is accepted only at the FILT_LEN-th consecutive clock edge at which clr_n_i is low. A shorter low pulse has no effect on any output.
- R5: An accepted clear while awake: the next PC is 0 and bits 7:5 are cleared. Bits 4:0 keep their value from status_i, and chip reset rises.
- R6: An accepted clear while asleep: the next PC is 0, bits 7:5 are 0, time-out is 1 and power-down is 0. Bits 2:0 are kept, and chip reset rises.
- R7: After an accepted clear, chip reset stays high while clr_n_i stays low. It falls on the cycle after clr_n_i is sampled high, provided the start-up count is finished.
- R8: A watchdog expiry while awake: the next PC is 0, bits 7:5 are 0, time-out is 0 and power-down is 1. Bits 2:0 are kept, and chip reset is high for one cycle.
- R9: A watchdog expiry while asleep: the next PC is pc_i+1, time-out is 0 and power-down is 0. All other status bits are kept, and chip reset is not raised.
- R10: An interrupt while asleep: time-out is 1 and power-down is 0, and other status bits are kept. The next PC is IRQ_VEC (default 4) when gie_i is 1. Otherwise it is pc_i+1, taken modulo 2^PC_W. Chip reset is not raised.
- R11: A pending interrupt while asleep_i is 0 produces no load and no status change.
- R12: pc_load_o pulses for one cycle in the cycle after the edge that sampled a condition, with pc_next_o and status_o valid in that cycle. pc_load_o is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| por_pulse_i | input | 1 | Power-rise pulse, also the block's reset |
| clr_n_i | input | 1 | External clear pin, active low, unfiltered |
| wdt_expire_i | input | 1 | Watchdog time-out strobe |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| gie_i | input | 1 | Global interrupt enable |
| asleep_i | input | 1 | Core is in sleep |
| pc_i | input | PC_W | Current program counter |
| status_i | input | 8 | Current status byte |
| chip_rst_o | output | 1 | Chip reset to the core |
| pc_next_o | output | PC_W | Program counter to load |
| pc_load_o | output | 1 | Strobe: load pc_next_o and status_o |
| status_o | output | 8 | Status byte with updated flags |

## Verification
Two pairs of events can fall in the same cycle. The first is a watchdog expiry together with a sleep-time interrupt. The second is an accepted clear together with a watchdog expiry. A power-rise pulse is also driven together with both a watchdog expiry and an interrupt. For the clear case, the watchdog strobe is placed on exactly the edge where the filter reaches its FILT_LEN-th low sample. In each case the scoreboard expects only the winning condition's PC, flag encoding and chip-reset level, and any second load strobe counts as an error.

// File: rtl/rstwake_pkg.sv
package rstwake_pkg;

   localparam int ST_W   = 8;
   localparam int TO_BIT = 4;
   localparam int PD_BIT = 3;

   typedef enum logic [2:0] {
      CAUSE_NONE      = 3'd0,
      CAUSE_POWER_ON  = 3'd1,
      CAUSE_CLR_RUN   = 3'd2,
      CAUSE_CLR_SLEEP = 3'd3,
      CAUSE_WDT_RUN   = 3'd4,
      CAUSE_WDT_WAKE  = 3'd5,
      CAUSE_IRQ_WAKE  = 3'd6
   } cause_e;

endpackage

// File: rtl/rw_clr_filter.sv
module rw_clr_filter #(
   parameter int FILT_LEN = 4
) (
   input  logic clk_i,
   input  logic sync_rst_i,
   input  logic pin_n_i,
   output logic hit_o,
   output logic held_o
);

   logic acc_q;

   if (FILT_LEN < 1) begin : g_bad_len
      $error("FILT_LEN must be at least 1");
   end

   if (FILT_LEN == 1) begin : g_direct
      assign hit_o = !pin_n_i && !acc_q;
   end else begin : g_count
      localparam int CW = $clog2(FILT_LEN);
      logic [CW-1:0] cnt_q;

      assign hit_o = !pin_n_i && !acc_q && (cnt_q == CW'(FILT_LEN - 1));

      always_ff @(posedge clk_i) begin
         if (sync_rst_i || pin_n_i) begin
            cnt_q <= '0;
         end else if (!acc_q && !hit_o) begin
            cnt_q <= cnt_q + CW'(1);
         end
      end

      // R4: an accepted clear needs the pin low on the previous edge too
      p_hit_needs_run_r4: assert property (@(posedge clk_i) disable iff (sync_rst_i)
         hit_o |-> $past(!pin_n_i))
         else $error("clear accepted without a run of low samples");
   end

   always_ff @(posedge clk_i) begin
      if (sync_rst_i || pin_n_i) begin
         acc_q <= 1'b0;
      end else if (hit_o) begin
         acc_q <= 1'b1;
      end
   end

   assign held_o = acc_q && !pin_n_i;

endmodule

// File: rtl/rw_cause_decode.sv
module rw_cause_decode
   import rstwake_pkg::*;
#(
   parameter int PC_W    = 13,
   parameter int IRQ_VEC = 4
) (
   input  logic              por_i,
   input  logic              clr_hit_i,
   input  logic              wdt_i,
   input  logic              irq_i,
   input  logic              gie_i,
   input  logic              sleep_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [ST_W-1:0]   st_i,
   output cause_e            cause_o,
   output logic [PC_W-1:0]   pc_o,
   output logic [ST_W-1:0]   st_o,
   output logic              rst_set_o
);

   logic [PC_W-1:0] pc_inc;
   assign pc_inc = pc_i + PC_W'(1);

   always_comb begin
      if (por_i) begin
         cause_o = CAUSE_POWER_ON;
      end else if (clr_hit_i) begin
         cause_o = sleep_i ? CAUSE_CLR_SLEEP : CAUSE_CLR_RUN;
      end else if (wdt_i) begin
         cause_o = sleep_i ? CAUSE_WDT_WAKE : CAUSE_WDT_RUN;
      end else if (irq_i && sleep_i) begin
         cause_o = CAUSE_IRQ_WAKE;
      end else begin
         cause_o = CAUSE_NONE;
      end
   end

   always_comb begin
      pc_o      = '0;
      st_o      = st_i;
      rst_set_o = 1'b0;
      unique case (cause_o)
         CAUSE_POWER_ON: begin
            st_o      = {3'b000, 1'b1, 1'b1, st_i[2:0]};
            rst_set_o = 1'b1;
         end
         CAUSE_CLR_RUN: begin
            st_o      = {3'b000, st_i[4:0]};
            rst_set_o = 1'b1;
         end
         CAUSE_CLR_SLEEP: begin
            st_o      = {3'b000, 1'b1, 1'b0, st_i[2:0]};
            rst_set_o = 1'b1;
         end
         CAUSE_WDT_RUN: begin
            st_o      = {3'b000, 1'b0, 1'b1, st_i[2:0]};
            rst_set_o = 1'b1;
         end
         CAUSE_WDT_WAKE: begin
            pc_o = pc_inc;
            st_o = {st_i[7:5], 1'b0, 1'b0, st_i[2:0]};
         end
         CAUSE_IRQ_WAKE: begin
            pc_o = gie_i ? PC_W'(IRQ_VEC) : pc_inc;
            st_o = {st_i[7:5], 1'b1, 1'b0, st_i[2:0]};
         end
         default: begin
            pc_o = pc_i;
         end
      endcase
   end

endmodule

// File: rtl/rw_startup_hold.sv
module rw_startup_hold #(
   parameter int STARTUP_CYC = 1024
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic set_i,
   input  logic hold_i,
   output logic rst_o
);

   localparam int CW = $clog2(STARTUP_CYC + 1);

   if (STARTUP_CYC < 1) begin : g_bad_cyc
      $error("STARTUP_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          rst_q;

   always_ff @(posedge clk_i) begin
      if (por_i) begin
         cnt_q <= CW'(STARTUP_CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   always_ff @(posedge clk_i) begin
      if (por_i || set_i) begin
         rst_q <= 1'b1;
      end else if ((cnt_q == '0) && !hold_i) begin
         rst_q <= 1'b0;
      end
   end

   assign rst_o = rst_q;

   // R3: reset is never released while the start-up count is running
   p_hold_while_counting_r3: assert property (@(posedge clk_i) disable iff (por_i)
      (cnt_q != '0) |=> rst_q)
      else $error("chip reset released during start-up count");

   // R7: a filtered clear that is still held keeps reset asserted
   p_hold_while_clear_r7: assert property (@(posedge clk_i) disable iff (por_i)
      hold_i |=> rst_q)
      else $error("chip reset released while clear held");

endmodule

// File: rtl/rstwake_ctrl.sv
module rstwake_ctrl
   import rstwake_pkg::*;
#(
   parameter int PC_W        = 13,
   parameter int FILT_LEN    = 4,
   parameter int STARTUP_CYC = 1024,
   parameter int IRQ_VEC     = 4
) (
   input  logic            clk_i,
   input  logic            por_pulse_i,
   input  logic            clr_n_i,
   input  logic            wdt_expire_i,
   input  logic            irq_pend_i,
   input  logic            gie_i,
   input  logic            asleep_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic [7:0]      status_i,
   output logic            chip_rst_o,
   output logic [PC_W-1:0] pc_next_o,
   output logic            pc_load_o,
   output logic [7:0]      status_o
);

   if (PC_W < 3) begin : g_bad_pc
      $error("PC_W too small for the interrupt vector");
   end
   if (IRQ_VEC < 0 || IRQ_VEC >= (1 << PC_W)) begin : g_bad_vec
      $error("IRQ_VEC outside the program counter range");
   end
   if (ST_W != 8) begin : g_bad_st
      $error("status layout assumes eight bits");
   end

   logic            clr_hit;
   logic            clr_held;
   cause_e          cause;
   logic [PC_W-1:0] pc_d;
   logic [ST_W-1:0] st_d;
   logic            rst_set;

   logic [PC_W-1:0] pc_q;
   logic [ST_W-1:0] st_q;
   logic            load_q;

   rw_clr_filter #(.FILT_LEN(FILT_LEN)) u_filter (
      .clk_i      (clk_i),
      .sync_rst_i (por_pulse_i),
      .pin_n_i    (clr_n_i),
      .hit_o      (clr_hit),
      .held_o     (clr_held)
   );

   rw_cause_decode #(.PC_W(PC_W), .IRQ_VEC(IRQ_VEC)) u_decode (
      .por_i     (por_pulse_i),
      .clr_hit_i (clr_hit),
      .wdt_i     (wdt_expire_i),
      .irq_i     (irq_pend_i),
      .gie_i     (gie_i),
      .sleep_i   (asleep_i),
      .pc_i      (pc_i),
      .st_i      (status_i),
      .cause_o   (cause),
      .pc_o      (pc_d),
      .st_o      (st_d),
      .rst_set_o (rst_set)
   );

   rw_startup_hold #(.STARTUP_CYC(STARTUP_CYC)) u_hold (
      .clk_i  (clk_i),
      .por_i  (por_pulse_i),
      .set_i  (rst_set),
      .hold_i (clr_held),
      .rst_o  (chip_rst_o)
   );

   always_ff @(posedge clk_i) begin
      load_q <= (cause != CAUSE_NONE);
      if (cause != CAUSE_NONE) begin
         pc_q <= pc_d;
         st_q <= st_d;
      end
   end

   assign pc_next_o = pc_q;
   assign status_o  = st_q;
   assign pc_load_o = load_q;

   // R9: a sleeping watchdog expiry resumes at PC+1 without reset
   p_wdt_wake_resume_r9: assert property (@(posedge clk_i) disable iff (por_pulse_i)
      (wdt_expire_i && asleep_i && !clr_hit && !chip_rst_o) |=>
         (pc_load_o && !chip_rst_o && pc_next_o == PC_W'($past(pc_i) + PC_W'(1))
          && status_o[TO_BIT] == 1'b0 && status_o[PD_BIT] == 1'b0))
      else $error("watchdog wake-up handled wrongly");

   // R10: interrupt wake with global enable jumps to the vector
   p_irq_vector_r10: assert property (@(posedge clk_i) disable iff (por_pulse_i)
      (asleep_i && irq_pend_i && gie_i && !wdt_expire_i && !clr_hit) |=>
         (pc_load_o && pc_next_o == PC_W'(IRQ_VEC)))
      else $error("interrupt wake-up did not load the vector");

   // R11: an interrupt while awake causes no load
   p_awake_irq_ignored_r11: assert property (@(posedge clk_i) disable iff (por_pulse_i)
      (!asleep_i && irq_pend_i && !wdt_expire_i && !clr_hit) |=> !pc_load_o)
      else $error("interrupt while awake produced a load");

   // R8: a fresh chip reset always comes with a zero program counter
   p_reset_zero_pc_r8: assert property (@(posedge clk_i) disable iff (por_pulse_i)
      $rose(chip_rst_o) |-> (pc_load_o && pc_next_o == '0))
      else $error("chip reset raised without PC load of zero");

endmodule

// File: tb/tb_rstwake_ctrl.sv
module tb_rstwake_ctrl;

   localparam int PERIOD = 10;
   localparam int PC_W   = 13;
   localparam int FILT   = 4;
   localparam int NCYC   = 1024;

   typedef struct {
      logic [PC_W-1:0] pc;
      logic [7:0]      st;
      logic            rst;
      string           tag;
   } exp_t;

   logic clk = 1'b0;
   logic por = 1'b1, clr_n = 1'b1, wdt = 1'b0, irq = 1'b0, gie = 1'b0, slp = 1'b0;
   logic [PC_W-1:0] pc = 13'h0ABC;
   logic [7:0]      st = 8'hE5;
   logic            chip_rst, pc_load;
   logic [PC_W-1:0] pc_next;
   logic [7:0]      st_out;

   int   checks = 0, errors = 0;
   exp_t sb[$];

   always #(PERIOD / 2) clk = ~clk;

   rstwake_ctrl #(.PC_W(PC_W), .FILT_LEN(FILT), .STARTUP_CYC(NCYC), .IRQ_VEC(4)) dut (
      .clk_i(clk), .por_pulse_i(por), .clr_n_i(clr_n), .wdt_expire_i(wdt),
      .irq_pend_i(irq), .gie_i(gie), .asleep_i(slp), .pc_i(pc), .status_i(st),
      .chip_rst_o(chip_rst), .pc_next_o(pc_next), .pc_load_o(pc_load), .status_o(st_out)
   );

   task automatic push(input logic [PC_W-1:0] p, input logic [7:0] s, input logic r,
                       input string tag);
      exp_t e;
      e.pc = p; e.st = s; e.rst = r; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: every load strobe is matched against the next expected item (R12)
   always @(negedge clk) begin
      if (pc_load) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R12: actual unexpected load pc=%0h st=%0h expected no load",
                     pc_next, st_out);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (pc_next !== e.pc || st_out !== e.st || chip_rst !== e.rst) begin
               errors++;
               $display("FAIL %s: actual pc=%0h st=%0h rst=%0b expected pc=%0h st=%0h rst=%0b",
                        e.tag, pc_next, st_out, chip_rst, e.pc, e.st, e.rst);
            end
         end
      end
   end

   initial begin
      #(PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R2: power-on, low status bits kept
      push('0, 8'h1D, 1'b1, "R2");
      @(negedge clk);
      por = 1'b0;
      // R3: start-up hold lasts NCYC+1 cycles after the pulse
      repeat (NCYC) @(negedge clk);
      chk(32'(chip_rst), 32'd1, "R3 still held");
      @(negedge clk);
      chk(32'(chip_rst), 32'd0, "R3 released");
      chk(32'(pc_load), 32'd0, "R12 idle strobe");

      // R4: short low pulse is ignored
      clr_n = 1'b0;
      repeat (FILT - 1) @(negedge clk);
      clr_n = 1'b1;
      @(negedge clk);
      chk(32'(chip_rst), 32'd0, "R4 glitch rejected");

      // R5 and R7: clear while running, held while pin low
      st = 8'hFF; slp = 1'b0;
      push('0, 8'h1F, 1'b1, "R5");
      clr_n = 1'b0;
      repeat (FILT) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(32'(chip_rst), 32'd1, "R7 held low pin");
      clr_n = 1'b1;
      @(negedge clk);
      chk(32'(chip_rst), 32'd0, "R7 released");

      // R6: clear while asleep
      slp = 1'b1; st = 8'hE0;
      push('0, 8'h10, 1'b1, "R6");
      clr_n = 1'b0;
      repeat (FILT) @(negedge clk);
      clr_n = 1'b1; slp = 1'b0;
      @(negedge clk);
      chk(32'(chip_rst), 32'd0, "R6 released");

      // R8: watchdog while running, one-cycle reset
      st = 8'hE7;
      push('0, 8'h0F, 1'b1, "R8");
      wdt = 1'b1;
      @(negedge clk);
      wdt = 1'b0;
      chk(32'(chip_rst), 32'd1, "R8 reset pulse");
      @(negedge clk);
      chk(32'(chip_rst), 32'd0, "R8 reset end");

      // R9: watchdog wake-up
      slp = 1'b1; pc = 13'h0123; st = 8'hFF;
      push(13'h0124, 8'hE7, 1'b0, "R9");
      wdt = 1'b1;
      @(negedge clk);
      wdt = 1'b0;

      // R10: interrupt wake-up without enable, PC wraps
      pc = 13'h1FFF; st = 8'h60; gie = 1'b0;
      push('0, 8'h70, 1'b0, "R10 wrap");
      irq = 1'b1;
      @(negedge clk);
      irq = 1'b0;

      // R10: interrupt wake-up with enable goes to vector
      pc = 13'h0200; st = 8'h07; gie = 1'b1;
      push(13'h0004, 8'h17, 1'b0, "R10 vector");
      irq = 1'b1;
      @(negedge clk);
      irq = 1'b0; gie = 1'b0;

      // R11: interrupt while awake is ignored
      slp = 1'b0; st = 8'h55;
      irq = 1'b1;
      @(negedge clk);
      irq = 1'b0;
      chk(32'(pc_load), 32'd0, "R11 no load");

      // R1: watchdog beats interrupt while asleep
      slp = 1'b1; pc = 13'h0010; st = 8'h18;
      push(13'h0011, 8'h00, 1'b0, "R1 wdt over irq");
      wdt = 1'b1; irq = 1'b1;
      @(negedge clk);
      wdt = 1'b0; irq = 1'b0; slp = 1'b0;

      // R1: accepted clear beats watchdog in the same cycle
      st = 8'hAB;
      push('0, 8'h0B, 1'b1, "R1 clr over wdt");
      clr_n = 1'b0;
      repeat (FILT - 1) @(negedge clk);
      wdt = 1'b1;
      @(negedge clk);
      wdt = 1'b0; clr_n = 1'b1;
      @(negedge clk);
      chk(32'(chip_rst), 32'd0, "R7 release after combo");

      // R1: power-rise beats everything
      slp = 1'b1; st = 8'hFF;
      push('0, 8'h1F, 1'b1, "R1 por over all");
      por = 1'b1; wdt = 1'b1; irq = 1'b1;
      @(negedge clk);
      por = 1'b0; wdt = 1'b0; irq = 1'b0; slp = 1'b0;
      repeat (NCYC + 1) @(negedge clk);
      chk(32'(chip_rst), 32'd0, "R3 second release");
      chk(32'(sb.size()), 32'd0, "R12 all loads seen");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule